// File: doc/BRIEF.md
# Multi-pass sign accumulator with carry recycling

This block decides whether a long serial stream of +1/-1 votes sums to a positive value, using only a tiny signed counter. The counter saturates at plus or minus N. When a vote would push it past that range, it records a signed carry worth N+1 votes and drops back to zero. Once the stream has ended, the block stores the sign of what remains in the counter. It then replays the recorded carries through the same counter, and each replay can produce a new, sparser set of carries. Replays continue until one of them produces no carry at all.

The resolve step walks the stored residual signs from the most recent pass back to the first. A later pass carries exponentially more weight, so the first non-zero sign met on this walk fixes the result. The block reports one step-function bit: 1 when the exact sum is strictly positive, 0 otherwise.

The host raises `start` for one cycle while the block is idle. From the next cycle on, it presents votes under `in_valid` and flags the final vote with `in_last`. It then waits for the single-cycle `done` strobe and reads `act` and `err`.

Top module: `exp_carry_counter`

## Requirements
- R1: The internal counter always stays within -RANGE_N..+RANGE_N. A step beyond either limit emits a carry of that sign, and the counter reads 0 on the following cycle.
- R2: For a stream of votes with `in_up`=1 meaning +1 and `in_up`=0 meaning -1, `act` at `done` equals 1 if the exact sum is greater than 0 and 0 otherwise.
- R3: After the vote pass, the stored carries are re-counted pass after pass until a pass emits no carry. The decision stays exact for streams long enough to need several such passes.
- R4: Residual signs are resolved from the latest pass to the earliest, and the first non-zero sign decides the result (positive gives 1, negative gives 0). If every sign is zero, the result is 0.
- R5: During a re-count pass, each new carry is written at an index below the next entry still to be read, so older carries are overwritten strictly in order.
- R6: `busy` is high from the cycle after an accepted `start` until the run ends. `done` is a one-cycle pulse, and `busy` is low while `done` is high.
- R7: `start` has no effect while `busy` is high. Votes presented while idle are ignored and produce no `done`.
- R8: If the carry store (CARRY_DEPTH entries) or the sign store (SIGN_DEPTH entries) would overflow, the run ends at once with `done`=1, `err`=1 and `act`=0.
- R9: After reset, `busy`, `done`, `act` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| in_valid | input | 1 | A vote is presented this cycle |
| in_up | input | 1 | Vote value: 1 = +1, 0 = -1 |
| in_last | input | 1 | The presented vote is the final one |
| busy | output | 1 | A run is in progress |
| act | output | 1 | Step activation of the summed stream |
| done | output | 1 | One-cycle strobe: `act` and `err` are valid |
| err | output | 1 | A carry or sign store overflowed in this run |

## Verification
A wrong internal state shows only at the `done` strobe, and only as a single bit. A bad counter limit, a dropped or misordered carry, or a wrong resolve order therefore appears as a wrong `act` on the streams whose sum lies close to zero, or whose decisive weight sits in a late pass.

For that reason, every stream of up to eight votes is swept exhaustively, and biased random streams of up to a few hundred votes force three or four passes. Each result is compared with the arithmetic sign of the stream. Handshake faults show up at once, as a missing, doubled or early `done`, or as a wrong `busy` level.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VOTE,
    ST_SAVE,
    ST_CARRY,
    ST_RESOLVE
  } ecc_state_e;

  typedef enum logic [1:0] {
    SG_ZERO = 2'b00,
    SG_POS  = 2'b01,
    SG_NEG  = 2'b10
  } sign_code_e;
endpackage

// File: rtl/ecc_acc.sv
module ecc_acc #(
  parameter int RANGE_N = 3,
  parameter int CW      = $clog2(RANGE_N + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 step,
  input  logic                 up,
  output logic signed [CW-1:0] cnt,
  output logic                 cy_fire,
  output logic                 cy_up
);
  localparam logic signed [CW-1:0] LIM  = CW'(RANGE_N);
  localparam logic signed [CW-1:0] NLIM = -LIM;
  localparam logic signed [CW-1:0] ONE  = CW'(1);

  assign cy_fire = step && (up ? (cnt == LIM) : (cnt == NLIM));
  assign cy_up   = up;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (step) begin
      if (cy_fire)    cnt <= '0;
      else if (up)    cnt <= cnt + ONE;
      else            cnt <= cnt - ONE;
    end
  end

  // R1: counter never leaves the symmetric window
  p_acc_range_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt <= LIM) && (cnt >= NLIM));

  // R1: an emitted carry leaves the counter at zero
  p_carry_zero_r1: assert property (@(posedge clk) disable iff (rst)
    cy_fire |=> (cnt == '0));
endmodule

// File: rtl/ecc_carry_ram.sv
module ecc_carry_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ecc_sign_file.sv
module ecc_sign_file #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [1:0]    wcode,
  input  logic [AW-1:0] raddr,
  output logic [1:0]    rcode
);
  logic [1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wcode;
  end

  assign rcode = regs[raddr];
endmodule

// File: rtl/exp_carry_counter.sv
module exp_carry_counter #(
  parameter int RANGE_N     = 3,
  parameter int CARRY_DEPTH = 64,
  parameter int SIGN_DEPTH  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_valid,
  input  logic in_up,
  input  logic in_last,
  output logic busy,
  output logic act,
  output logic done,
  output logic err
);
  import ecc_pkg::*;

  localparam int CW  = $clog2(RANGE_N + 1) + 1;
  localparam int CAW = $clog2(CARRY_DEPTH);
  localparam int CIW = $clog2(CARRY_DEPTH + 1);
  localparam int SAW = $clog2(SIGN_DEPTH);
  localparam int SIW = $clog2(SIGN_DEPTH + 1);

  ecc_state_e state;
  logic [CIW-1:0] cwr, prev_cnt, rd_idx;
  logic [SIW-1:0] swr;
  logic [SAW-1:0] ridx;
  logic rd_valid, act_q, done_q, err_q;

  logic signed [CW-1:0] cnt;
  logic acc_step, acc_up, acc_clr, cy_fire, cy_up;
  logic carry_q, c_we, c_full, issue, s_we;
  logic [1:0] wcode, rcode;

  assign issue    = (state == ST_CARRY) && (rd_idx < prev_cnt);
  assign acc_step = ((state == ST_VOTE) && in_valid) || ((state == ST_CARRY) && rd_valid);
  assign acc_up   = (state == ST_CARRY) ? carry_q : in_up;
  assign acc_clr  = ((state == ST_IDLE) && start) || (state == ST_SAVE);
  assign c_we     = cy_fire && (cwr < CIW'(CARRY_DEPTH));
  assign c_full   = cy_fire && (cwr == CIW'(CARRY_DEPTH));
  assign s_we     = (state == ST_SAVE) && (swr < SIW'(SIGN_DEPTH));
  assign wcode    = (cnt > 0) ? SG_POS : ((cnt < 0) ? SG_NEG : SG_ZERO);

  ecc_acc #(.RANGE_N(RANGE_N), .CW(CW)) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .step(acc_step), .up(acc_up),
    .cnt(cnt), .cy_fire(cy_fire), .cy_up(cy_up)
  );

  ecc_carry_ram #(.DEPTH(CARRY_DEPTH), .AW(CAW)) u_carry (
    .clk(clk), .we(c_we), .waddr(cwr[CAW-1:0]), .wdata(cy_up),
    .raddr(rd_idx[CAW-1:0]), .rdata(carry_q)
  );

  ecc_sign_file #(.DEPTH(SIGN_DEPTH), .AW(SAW)) u_sign (
    .clk(clk), .we(s_we), .waddr(swr[SAW-1:0]), .wcode(wcode),
    .raddr(ridx), .rcode(rcode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cwr      <= '0;
      prev_cnt <= '0;
      rd_idx   <= '0;
      swr      <= '0;
      ridx     <= '0;
      rd_valid <= 1'b0;
      act_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      rd_valid <= issue;
      case (state)
        ST_IDLE: if (start) begin
          cwr   <= '0;
          swr   <= '0;
          err_q <= 1'b0;
          act_q <= 1'b0;
          state <= ST_VOTE;
        end
        ST_VOTE: if (in_valid) begin
          if (c_full) begin
            err_q  <= 1'b1;
            act_q  <= 1'b0;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            if (cy_fire) cwr <= cwr + 1'b1;
            if (in_last) state <= ST_SAVE;
          end
        end
        ST_CARRY: begin
          if (issue) rd_idx <= rd_idx + 1'b1;
          if (rd_valid) begin
            if (cy_fire) cwr <= cwr + 1'b1;
            if (rd_idx == prev_cnt) state <= ST_SAVE;
          end
        end
        ST_SAVE: begin
          if (swr == SIW'(SIGN_DEPTH)) begin
            err_q  <= 1'b1;
            act_q  <= 1'b0;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            swr <= swr + 1'b1;
            if (cwr == '0) begin
              ridx  <= swr[SAW-1:0];
              state <= ST_RESOLVE;
            end else begin
              prev_cnt <= cwr;
              cwr      <= '0;
              rd_idx   <= '0;
              state    <= ST_CARRY;
            end
          end
        end
        ST_RESOLVE: begin
          if (rcode == SG_POS) begin
            act_q <= 1'b1; done_q <= 1'b1; state <= ST_IDLE;
          end else if (rcode == SG_NEG || ridx == '0) begin
            act_q <= 1'b0; done_q <= 1'b1; state <= ST_IDLE;
          end else begin
            ridx <= ridx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign act  = act_q;
  assign done = done_q;
  assign err  = err_q;

  // R5: re-count writes trail the read pointer
  p_overwrite_order_r5: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_CARRY) && c_we) |-> (cwr < rd_idx));

  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: done is never seen while busy
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4: a zero sign with earlier entries keeps the scan going
  p_resolve_walk_r4: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RESOLVE) && (rcode == SG_ZERO) && (ridx != '0)) |=> (state == ST_RESOLVE));

  // R8: an error is reported together with done and a zero activation
  p_err_done_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (done && !act));
endmodule

// File: tb/exp_carry_counter_tb.sv
`timescale 1ns/1ps
module exp_carry_counter_tb;
  logic clk = 1'b0;
  logic rst, start, in_valid, in_up, in_last;
  logic busy, act, done, err;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  logic got_act, got_err, got_busy;
  bit finished = 0;

  always #2 clk = ~clk;

  exp_carry_counter u_dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_up(in_up),
    .in_last(in_last), .busy(busy), .act(act), .done(done), .err(err)
  );

  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      got_act  = act;
      got_err  = err;
      got_busy = busy;
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expect_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expect_v);
    end
  endtask

  task automatic run(input int len, input logic [511:0] v, input bit poke_start,
                     output int exp_act, output bit timed_out);
    int sum = 0;
    int wd = 0;
    timed_out = 0;
    done_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_up    = v[i];
      in_last  = (i == len - 1);
      start    = poke_start && (i == len / 2);
      sum     += v[i] ? 1 : -1;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; start = 1'b0;
    exp_act = (sum > 0) ? 1 : 0;
    while (done_cnt == 0 && wd < 3000) begin
      @(negedge clk);
      wd++;
    end
    if (done_cnt == 0) timed_out = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_check(input int len, input logic [511:0] v, input bit poke, input string tag);
    int e;
    bit to;
    run(len, v, poke, e, to);
    check(!to, {tag, " watchdog"}, 0, 1);
    check(got_act == e, tag, int'(got_act), e);
    check(got_err == 1'b0, {tag, " err"}, int'(got_err), 0);
    check(done_cnt == 1, "R6 done width", done_cnt, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [511:0] v;
    int e;
    bit to;
    rst = 1'b1; start = 0; in_valid = 0; in_up = 0; in_last = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(!busy && !done && !act && !err, "R9 reset", int'({busy, done, act, err}), 0);

    // R2 exhaustive sweep up to eight votes
    for (int len = 1; len <= 8; len++)
      for (int p = 0; p < (1 << len); p++) begin
        v = '0;
        v[7:0] = p[7:0];
        run_check(len, v, 1'b0, "R2 sweep");
      end

    // R4 earliest negative, latest positive: 4 up then 3 down, sum +1
    v = '0; v[3:0] = 4'hF;
    run_check(7, v, 1'b0, "R4 latest sign wins");
    // R4 all residuals zero: 4 up then 4 down
    v = '0; v[3:0] = 4'hF;
    run_check(8, v, 1'b0, "R4 all zero");
    // R1 carry boundary: exactly RANGE_N+1 ups then none
    v = '0; v[3:0] = 4'hF;
    run_check(4, v, 1'b0, "R1 carry at limit");

    // R3/R5 long biased random streams, several passes
    for (int k = 0; k < 40; k++) begin
      int len = 60 + int'($urandom % 190);
      int bias = 30 + (k % 5) * 10;
      v = '0;
      for (int i = 0; i < len; i++) v[i] = (($urandom % 100) < bias);
      run_check(len, v, 1'b0, (k % 2) ? "R3 multi-pass" : "R5 carry order");
    end
    // R3 all-up long stream forcing maximal passes
    v = '1;
    run_check(250, v, 1'b0, "R3 all up");
    v = '0;
    run_check(250, v, 1'b0, "R3 all down");

    // R7 start pulsed mid-stream is ignored
    v = '0;
    for (int i = 0; i < 40; i++) v[i] = (i % 3 != 0);
    run_check(40, v, 1'b1, "R7 start while busy");

    // R7 votes while idle: no busy, no done
    done_cnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_up = 1'b1; in_last = (i == 4);
      check(!busy, "R7 idle busy", int'(busy), 0);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    repeat (4) @(negedge clk);
    check(done_cnt == 0, "R7 idle done", done_cnt, 0);

    // R6 busy during run, low at done
    fork
      begin
        v = '1;
        run(20, v, 1'b0, e, to);
      end
      begin
        repeat (4) @(negedge clk);
        check(busy, "R6 busy in run", int'(busy), 1);
      end
    join
    check(got_busy == 1'b0, "R6 busy at done", int'(got_busy), 0);
    check(got_act == 1'b1, "R6 result", int'(got_act), 1);

    // R8 carry store overflow: 300 ups give 75 carries > 64
    v = '1;
    run(300, v, 1'b0, e, to);
    check(!to, "R8 watchdog", 0, 1);
    check(got_err == 1'b1, "R8 err", int'(got_err), 1);
    check(got_act == 1'b0, "R8 act", int'(got_act), 0);
    check(done_cnt == 1, "R8 done once", done_cnt, 1);

    // R2 normal run after an error
    v = '0; v[2:0] = 3'b111;
    run_check(5, v, 1'b0, "R2 after error");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule